// File: doc/BRIEF.md
# Interrupt-Triggered Eight-Channel DMA Engine

This block moves data on behalf of peripheral interrupts. It has no dedicated request lines. Each of its channels holds a trigger vector. When an interrupt with that vector arrives, the channel latches a pending request. The engine serves pending channels one at a time. For each service it moves a single unit of 1, 2 or 4 bytes: it reads the unit from the channel's source address and writes it to the channel's destination address over a simple request/ready memory bus.

After each unit the channel's counter steps down by one. The channel stays armed while units remain. When the last unit has gone, the channel raises a one-cycle completion interrupt on its own line and clears its trigger vector, so later interrupts with that vector flow on to the CPU as ordinary interrupts. Interrupts that match no armed channel are passed through unchanged in the same cycle. While any DMA request is pending, the engine announces it to the CPU at the top maskable level, 6. A halt input keeps pending requests waiting without serving them.

Software programs the channels through a write-only register port: a channel index, a register select and a data word. The engine never changes the source or destination address.

Top module: `irq_dma_engine`

## Requirements
- R1: After reset, `busy`, `memReq`, `tcIrq` and `svcLevel` are all 0, and no channel is armed.
- R2: An interrupt whose nonzero vector equals the trigger vector of a channel sets that channel's pending request and is not passed on. Any other interrupt appears on `irqPassValid`/`irqPassVec` in the same cycle. `svcLevel` is 6 while any request is pending and 0 otherwise.
- R3: One service reads from the channel's source address and then writes the data read to its destination address. Both phases use the same byte enables, set by the size code: 0 gives 4'b0001 (1 byte), 1 gives 4'b0011 (2 bytes), 2 or 3 gives 4'b1111 (4 bytes). The addresses stay the same from one service to the next.
- R4: Each service decrements the channel counter by one. If units remain, the trigger vector is kept and the channel serves the next matching interrupt.
- R5: The service that moves the last unit pulses `tcIrq[ch]` high for exactly one cycle, in the cycle after the write handshake, and clears the trigger vector. A later interrupt with that vector is then passed on.
- R6: When several channels are pending, the lowest-numbered channel is served first.
- R7: While `haltIn` is high, no new service starts. Pending requests are kept and are served once `haltIn` falls.
- R8: `busy` and `memReq` are high from acceptance until the write handshake. `memReq`, `memWe` and `memAddr` hold steady while `memReady` is low. After each service the engine is idle for at least one cycle.
- R9: A counter value of 0 written to the count register means 2^CNT_W units.
- R10: Accepting a request clears that channel's pending flag, so each matching interrupt yields exactly one service.
- R11: Register selects are: 0 trigger vector (writing it also clears that channel's pending flag), 1 source address, 2 destination address, 3 size code in bits [1:0], 4 count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Register write strobe |
| cfgCh | input | CH_W | Channel index of the write |
| cfgSel | input | 3 | Register select (R11) |
| cfgData | input | ADDR_W | Write data |
| irqValid | input | 1 | An interrupt is presented this cycle |
| irqVec | input | VEC_W | Vector of the presented interrupt |
| haltIn | input | 1 | CPU halted: hold DMA requests |
| irqPassValid | output | 1 | Interrupt passed on as a normal interrupt |
| irqPassVec | output | VEC_W | Vector of the passed interrupt |
| svcLevel | output | 3 | 6 while a DMA request is pending, else 0 |
| busy | output | 1 | A service is in progress |
| tcIrq | output | NUM_CH | Per-channel completion pulse |
| memReq | output | 1 | Bus request |
| memWe | output | 1 | 1 for the write phase, 0 for the read phase |
| memAddr | output | ADDR_W | Bus address |
| memBe | output | 4 | Byte enables |
| memWdata | output | 32 | Write data |
| memRdata | input | 32 | Read data |
| memReady | input | 1 | Bus handshake complete |

## Verification
The bench builds the engine with eight channels, 8-bit vectors, 32-bit addresses and CNT_W set to 4. The narrow counter makes the case where a written count of 0 means the maximum number of units cost only sixteen services, so it can be run to completion. It also keeps random counts small enough that channels run out and disarm often, which exercises pass-through after completion. Requests are queued under halt before each release, so several channels are pending at once and the arbitration order is observed on the bus. Bus ready is delayed at random to test that the request holds steady.

// File: rtl/irq_dma_pkg.sv
package irq_dma_pkg;

  localparam int BUS_BYTES = 4;
  localparam int BUS_W     = 8 * BUS_BYTES;
  localparam logic [2:0] DMA_LEVEL = 3'd6;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_READ  = 2'd1,
    ST_WRITE = 2'd2
  } dmaState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic accept;
    logic rdDone;
    logic wrDone;
  } dmaStrobe_t;

  localparam logic [2:0] SEL_VEC  = 3'd0;
  localparam logic [2:0] SEL_SRC  = 3'd1;
  localparam logic [2:0] SEL_DST  = 3'd2;
  localparam logic [2:0] SEL_SIZE = 3'd3;
  localparam logic [2:0] SEL_CNT  = 3'd4;

  function automatic logic [BUS_BYTES-1:0] sizeToBe(input logic [1:0] sz);
    case (sz)
      2'd0:    return 4'b0001;
      2'd1:    return 4'b0011;
      default: return 4'b1111;
    endcase
  endfunction

endpackage

// File: rtl/irq_dma_datapath.sv
module irq_dma_datapath
  import irq_dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 cfgWe,
  input  logic [CH_W-1:0]      cfgCh,
  input  logic [2:0]           cfgSel,
  input  logic [ADDR_W-1:0]    cfgData,
  input  logic                 irqValid,
  input  logic [VEC_W-1:0]     irqVec,
  input  dmaStrobe_t           strobe,
  input  logic [CH_W-1:0]      selCh,
  input  logic [BUS_W-1:0]     memRdata,
  output logic [NUM_CH-1:0]    pendMask,
  output logic                 irqPassValid,
  output logic [VEC_W-1:0]     irqPassVec,
  output logic [ADDR_W-1:0]    curSrc,
  output logic [ADDR_W-1:0]    curDst,
  output logic [BUS_BYTES-1:0] curBe,
  output logic [BUS_W-1:0]     wrData,
  output logic [NUM_CH-1:0]    tcIrq
);

  logic [VEC_W-1:0]  vecArr  [NUM_CH];
  logic [ADDR_W-1:0] srcArr  [NUM_CH];
  logic [ADDR_W-1:0] dstArr  [NUM_CH];
  logic [1:0]        sizeArr [NUM_CH];
  logic [CNT_W-1:0]  cntArr  [NUM_CH];
  logic [NUM_CH-1:0] matchHit;
  logic [BUS_W-1:0]  dataQ;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    logic [VEC_W-1:0]  vecR;
    logic [ADDR_W-1:0] srcR, dstR;
    logic [1:0]        sizeR;
    logic [CNT_W-1:0]  cntR;
    logic              pendR, tcR;
    logic              cfgHit, mine, lastUnit;

    assign cfgHit   = cfgWe && (cfgCh == CH_W'(i));
    assign mine     = (selCh == CH_W'(i));
    assign lastUnit = (cntR == CNT_W'(1));
    assign matchHit[i] = irqValid && (vecR != '0) && (irqVec == vecR);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        vecR  <= '0;
        srcR  <= '0;
        dstR  <= '0;
        sizeR <= '0;
        cntR  <= '0;
        pendR <= 1'b0;
        tcR   <= 1'b0;
      end else begin
        if (cfgHit && cfgSel == SEL_VEC)         vecR <= cfgData[VEC_W-1:0];
        else if (strobe.wrDone && mine && lastUnit) vecR <= '0;
        if (cfgHit && cfgSel == SEL_SRC)  srcR  <= cfgData;
        if (cfgHit && cfgSel == SEL_DST)  dstR  <= cfgData;
        if (cfgHit && cfgSel == SEL_SIZE) sizeR <= cfgData[1:0];
        if (cfgHit && cfgSel == SEL_CNT)  cntR  <= cfgData[CNT_W-1:0];
        else if (strobe.wrDone && mine)   cntR  <= cntR - CNT_W'(1);
        if (matchHit[i])                                            pendR <= 1'b1;
        else if ((strobe.accept && mine) || (cfgHit && cfgSel == SEL_VEC)) pendR <= 1'b0;
        tcR <= strobe.wrDone && mine && lastUnit;
      end
    end

    assign vecArr[i]  = vecR;
    assign srcArr[i]  = srcR;
    assign dstArr[i]  = dstR;
    assign sizeArr[i] = sizeR;
    assign cntArr[i]  = cntR;
    assign pendMask[i] = pendR;
    assign tcIrq[i]    = tcR;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              dataQ <= '0;
    else if (strobe.rdDone) dataQ <= memRdata;
  end

  assign irqPassValid = irqValid && !(|matchHit);
  assign irqPassVec   = irqVec;
  assign curSrc = srcArr[selCh];
  assign curDst = dstArr[selCh];
  assign curBe  = sizeToBe(sizeArr[selCh]);
  assign wrData = dataQ;

endmodule

// File: rtl/irq_dma_ctrl.sv
module irq_dma_ctrl
  import irq_dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_CH-1:0] pendMask,
  input  logic              haltIn,
  input  logic              memReady,
  output dmaStrobe_t        strobe,
  output logic [CH_W-1:0]   selCh,
  output logic              busy,
  output logic              memReq,
  output logic              memWe
);

  dmaState_t       state;
  logic [CH_W-1:0] curCh, arbCh;
  logic            anyPend;

  // Fixed priority: lowest index wins
  always_comb begin
    arbCh   = '0;
    anyPend = 1'b0;
    for (int i = NUM_CH - 1; i >= 0; i--) begin
      if (pendMask[i]) begin
        arbCh   = CH_W'(i);
        anyPend = 1'b1;
      end
    end
  end

  always_comb begin
    strobe.accept = (state == ST_IDLE) && anyPend && !haltIn;
    strobe.rdDone = (state == ST_READ) && memReady;
    strobe.wrDone = (state == ST_WRITE) && memReady;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      curCh <= '0;
    end else begin
      case (state)
        ST_IDLE:  if (strobe.accept) begin
                    state <= ST_READ;
                    curCh <= arbCh;
                  end
        ST_READ:  if (strobe.rdDone) state <= ST_WRITE;
        ST_WRITE: if (strobe.wrDone) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign selCh  = (state == ST_IDLE) ? arbCh : curCh;
  assign memReq = (state != ST_IDLE);
  assign memWe  = (state == ST_WRITE);
  assign busy   = memReq;

endmodule

// File: rtl/irq_dma_engine.sv
module irq_dma_engine
  import irq_dma_pkg::*;
#(
  parameter int NUM_CH = 8,
  parameter int VEC_W  = 8,
  parameter int ADDR_W = 32,
  parameter int CNT_W  = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cfgWe,
  input  logic [CH_W-1:0]   cfgCh,
  input  logic [2:0]        cfgSel,
  input  logic [ADDR_W-1:0] cfgData,
  input  logic              irqValid,
  input  logic [VEC_W-1:0]  irqVec,
  input  logic              haltIn,
  output logic              irqPassValid,
  output logic [VEC_W-1:0]  irqPassVec,
  output logic [2:0]        svcLevel,
  output logic              busy,
  output logic [NUM_CH-1:0] tcIrq,
  output logic              memReq,
  output logic              memWe,
  output logic [ADDR_W-1:0] memAddr,
  output logic [3:0]        memBe,
  output logic [31:0]       memWdata,
  input  logic [31:0]       memRdata,
  input  logic              memReady
);

  dmaStrobe_t        strobe;
  logic [CH_W-1:0]   selCh;
  logic [NUM_CH-1:0] pendMask;
  logic [ADDR_W-1:0] curSrc, curDst;

  irq_dma_ctrl #(.NUM_CH(NUM_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .pendMask(pendMask), .haltIn(haltIn),
    .memReady(memReady), .strobe(strobe), .selCh(selCh), .busy(busy),
    .memReq(memReq), .memWe(memWe)
  );

  irq_dma_datapath #(.NUM_CH(NUM_CH), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dp (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSel(cfgSel),
    .cfgData(cfgData), .irqValid(irqValid), .irqVec(irqVec), .strobe(strobe),
    .selCh(selCh), .memRdata(memRdata), .pendMask(pendMask),
    .irqPassValid(irqPassValid), .irqPassVec(irqPassVec), .curSrc(curSrc),
    .curDst(curDst), .curBe(memBe), .wrData(memWdata), .tcIrq(tcIrq)
  );

  assign memAddr  = memWe ? curDst : curSrc;
  assign svcLevel = (|pendMask) ? DMA_LEVEL : 3'd0;

endmodule

// File: rtl/irq_dma_checker.sv
module irq_dma_checker #(
  parameter int NUM_CH = 8,
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              haltIn,
  input logic              busy,
  input logic              memReq,
  input logic              memWe,
  input logic              memReady,
  input logic [ADDR_W-1:0] memAddr,
  input logic [3:0]        memBe,
  input logic [NUM_CH-1:0] tcIrq,
  input logic [2:0]        svcLevel
);

  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq && $stable(memWe) && $stable(memAddr));

  p_halt_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    haltIn && !busy |=> !busy);

  p_tc_after_write_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|tcIrq) |-> $past(memReq && memWe && memReady));

  p_tc_onehot_r5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tcIrq));

  p_tc_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    (|tcIrq) |=> tcIrq == '0);

  p_be_legal_r3: assert property (@(posedge clk) disable iff (!rstN)
    memReq |-> (memBe == 4'b0001 || memBe == 4'b0011 || memBe == 4'b1111));

  p_level_r2: assert property (@(posedge clk) disable iff (!rstN)
    svcLevel == 3'd0 || svcLevel == 3'd6);

  p_idle_gap_r8: assert property (@(posedge clk) disable iff (!rstN)
    memReq && memWe && memReady |=> !memReq);

endmodule

bind irq_dma_engine irq_dma_checker #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .haltIn(haltIn), .busy(busy), .memReq(memReq),
  .memWe(memWe), .memReady(memReady), .memAddr(memAddr), .memBe(memBe),
  .tcIrq(tcIrq), .svcLevel(svcLevel)
);

// File: tb/irq_dma_engine_tb.sv
`timescale 1ns/1ps
module irq_dma_engine_tb;
  localparam int NUM_CH = 8;
  localparam int VEC_W  = 8;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 4;
  localparam int CH_W   = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cfgWe = 1'b0;
  logic [CH_W-1:0] cfgCh = '0;
  logic [2:0] cfgSel = '0;
  logic [ADDR_W-1:0] cfgData = '0;
  logic irqValid = 1'b0;
  logic [VEC_W-1:0] irqVec = '0;
  logic haltIn = 1'b1;
  logic irqPassValid;
  logic [VEC_W-1:0] irqPassVec;
  logic [2:0] svcLevel;
  logic busy;
  logic [NUM_CH-1:0] tcIrq;
  logic memReq, memWe;
  logic [ADDR_W-1:0] memAddr;
  logic [3:0] memBe;
  logic [31:0] memWdata;
  logic [31:0] memRdata = '0;
  logic memReady = 1'b0;

  always #4 clk = ~clk;

  irq_dma_engine #(.NUM_CH(NUM_CH), .VEC_W(VEC_W), .ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_dut (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgCh(cfgCh), .cfgSel(cfgSel),
    .cfgData(cfgData), .irqValid(irqValid), .irqVec(irqVec), .haltIn(haltIn),
    .irqPassValid(irqPassValid), .irqPassVec(irqPassVec), .svcLevel(svcLevel),
    .busy(busy), .tcIrq(tcIrq), .memReq(memReq), .memWe(memWe), .memAddr(memAddr),
    .memBe(memBe), .memWdata(memWdata), .memRdata(memRdata), .memReady(memReady)
  );

  int compared = 0;
  int mismatched = 0;

  logic [VEC_W-1:0]  mVec  [NUM_CH];
  logic [ADDR_W-1:0] mSrc  [NUM_CH];
  logic [ADDR_W-1:0] mDst  [NUM_CH];
  logic [1:0]        mSize [NUM_CH];
  int                mCnt  [NUM_CH];
  bit                mPend [NUM_CH];

  function automatic logic [3:0] expBe(input logic [1:0] sz);
    return (sz == 2'd0) ? 4'b0001 : (sz == 2'd1) ? 4'b0011 : 4'b1111;
  endfunction

  function automatic logic [31:0] beMask(input logic [3:0] be);
    logic [31:0] m;
    for (int b = 0; b < 4; b++) m[8*b +: 8] = {8{be[b]}};
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfgWrite(input int ch, input logic [2:0] sel, input logic [31:0] data);
    cfgWe = 1'b1; cfgCh = CH_W'(ch); cfgSel = sel; cfgData = data;
    @(negedge clk);
    cfgWe = 1'b0;
    case (sel)
      3'd0: begin mVec[ch] = data[VEC_W-1:0]; mPend[ch] = 1'b0; end
      3'd1: mSrc[ch] = data;
      3'd2: mDst[ch] = data;
      3'd3: mSize[ch] = data[1:0];
      default: mCnt[ch] = (data[CNT_W-1:0] == 0) ? (1 << CNT_W) : int'(data[CNT_W-1:0]);
    endcase
  endtask

  task automatic setupCh(input int ch, input logic [7:0] vec, input logic [1:0] sz,
                         input int cnt, input logic [31:0] src, input logic [31:0] dst);
    cfgWrite(ch, 3'd1, src);
    cfgWrite(ch, 3'd2, dst);
    cfgWrite(ch, 3'd3, {30'd0, sz});
    cfgWrite(ch, 3'd4, 32'(cnt));
    cfgWrite(ch, 3'd0, {24'd0, vec});
  endtask

  // Called with haltIn high
  task automatic fireIrq(input logic [7:0] vec);
    bit hit = 1'b0;
    for (int c = 0; c < NUM_CH; c++) if (mVec[c] != 0 && mVec[c] == vec) hit = 1'b1;
    irqValid = 1'b1; irqVec = vec;
    #1;
    chk(irqPassValid == !hit, "R2", "pass-through valid", 64'(irqPassValid), 64'(!hit));
    if (!hit) chk(irqPassVec == vec, "R2", "pass-through vector", 64'(irqPassVec), 64'(vec));
    @(negedge clk);
    irqValid = 1'b0;
    for (int c = 0; c < NUM_CH; c++) if (mVec[c] != 0 && mVec[c] == vec) mPend[c] = 1'b1;
    chk(svcLevel == (hit || anyPendM() ? 3'd6 : 3'd0), "R2", "svcLevel",
        64'(svcLevel), 64'(anyPendM() ? 6 : 0));
  endtask

  function automatic bit anyPendM();
    for (int c = 0; c < NUM_CH; c++) if (mPend[c]) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int lowestPend();
    for (int c = 0; c < NUM_CH; c++) if (mPend[c]) return c;
    return -1;
  endfunction

  task automatic serviceOne();
    int ch = lowestPend();
    int guard = 0;
    logic [31:0] rd;
    logic [NUM_CH-1:0] expTc;
    while (!memReq && guard < 20) begin @(negedge clk); guard++; end
    chk(memReq, "R7", "service starts after halt release", 64'(memReq), 64'd1);
    chk(!memWe && memAddr == mSrc[ch], "R6", "read address of lowest pending channel",
        64'(memAddr), 64'(mSrc[ch]));
    chk(memBe == expBe(mSize[ch]), "R3", "read byte enables", 64'(memBe), 64'(expBe(mSize[ch])));
    chk(busy, "R8", "busy during read", 64'(busy), 64'd1);
    mPend[ch] = 1'b0;
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(memReq && !memWe && memAddr == mSrc[ch], "R8", "read held while not ready",
          64'(memAddr), 64'(mSrc[ch]));
    end
    rd = $urandom;
    memRdata = rd; memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
    chk(memReq && memWe && memAddr == mDst[ch], "R3", "write address",
        64'(memAddr), 64'(mDst[ch]));
    chk((memWdata & beMask(expBe(mSize[ch]))) == (rd & beMask(expBe(mSize[ch]))), "R3",
        "write data", 64'(memWdata), 64'(rd));
    chk(memBe == expBe(mSize[ch]), "R3", "write byte enables", 64'(memBe), 64'(expBe(mSize[ch])));
    repeat ($urandom_range(0, 2)) begin
      @(negedge clk);
      chk(memReq && memWe, "R8", "write held while not ready", 64'(memWe), 64'd1);
    end
    memReady = 1'b1;
    @(negedge clk);
    memReady = 1'b0;
    mCnt[ch]--;
    expTc = '0;
    if (mCnt[ch] == 0) begin
      expTc[ch] = 1'b1;
      mVec[ch] = '0;
    end
    chk(tcIrq == expTc, (mCnt[ch] == 0) ? "R5" : "R4", "completion pulse",
        64'(tcIrq), 64'(expTc));
    chk(!busy && !memReq, "R8", "idle after write", 64'(busy), 64'd0);
    @(negedge clk);
    chk(tcIrq == '0, "R5", "pulse lasts one cycle", 64'(tcIrq), 64'd0);
  endtask

  task automatic serviceAll();
    haltIn = 1'b0;
    while (anyPendM()) serviceOne();
    repeat (3) @(negedge clk);
    chk(!memReq, "R10", "no extra service", 64'(memReq), 64'd0);
    haltIn = 1'b1;
  endtask

  initial begin
    #(8ns * 150000);
    mismatched++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    for (int c = 0; c < NUM_CH; c++) begin
      mVec[c] = '0; mSrc[c] = '0; mDst[c] = '0; mSize[c] = '0; mCnt[c] = 1 << CNT_W; mPend[c] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    chk(!busy && !memReq && tcIrq == '0 && svcLevel == 0, "R1", "reset state",
        {busy, memReq, tcIrq, svcLevel}, 64'd0);
    fireIrq(8'h21); // nothing armed: R1, passes through

    // Directed: priority, halt, count, disarm
    setupCh(3, 8'h21, 2'd0, 2, 32'h1000_0030, 32'h2000_0030);
    setupCh(1, 8'h22, 2'd2, 1, 32'h1000_0010, 32'h2000_0010);
    fireIrq(8'h21);
    fireIrq(8'h22);
    fireIrq(8'h55);
    repeat (4) @(negedge clk);
    chk(!memReq && svcLevel == 3'd6, "R7", "requests held under halt", 64'(memReq), 64'd0);
    serviceAll();
    fireIrq(8'h22); // ch1 disarmed: passes
    chk(svcLevel == 3'd0, "R5", "disarmed channel not pending", 64'(svcLevel), 64'd0);
    fireIrq(8'h21); // ch3 still armed
    serviceAll();
    fireIrq(8'h21);

    // Count of zero means 2^CNT_W units
    setupCh(7, 8'h30, 2'd1, 0, 32'h1000_0070, 32'h2000_0070);
    for (int k = 0; k < (1 << CNT_W); k++) begin
      fireIrq(8'h30);
      serviceAll();
    end
    chk(mVec[7] == 0, "R9", "model count wrap", 64'(mVec[7]), 64'd0);
    fireIrq(8'h30);

    // Vector write clears pending (R11)
    setupCh(2, 8'h44, 2'd0, 3, 32'h1000_0020, 32'h2000_0020);
    fireIrq(8'h44);
    cfgWrite(2, 3'd0, 32'h45);
    chk(svcLevel == 3'd0, "R11", "vector write clears pending", 64'(svcLevel), 64'd0);

    // Random rounds
    for (int r = 0; r < 40; r++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        logic [7:0] v = ($urandom_range(0, 3) == 0) ? 8'h00 : (8'h80 | 8'(c << 3) | 8'($urandom_range(0, 7)));
        setupCh(c, v, 2'($urandom_range(0, 3)), $urandom_range(1, 3), $urandom, $urandom);
      end
      for (int n = 0; n < $urandom_range(1, 6); n++) begin
        if ($urandom_range(0, 3) == 0) fireIrq(8'($urandom_range(1, 127)));
        else fireIrq(mVec[$urandom_range(0, NUM_CH - 1)] | 8'h80);
      end
      serviceAll();
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule